// File: doc/BRIEF.md
# Dual-Clock Real-Time Counter with Write Tracking

This peripheral keeps time in a slow tick clock domain while software reaches it through a simple register port on a fast bus clock. The slow side holds a sub-second counter that wraps at a parameter value, a second counter advanced by each wrap, a compare alarm for each counter and a four-bit control word. An interrupt becomes pending when a counting counter equals its alarm. One interrupt line is the OR of the pending flags, each masked by its own enable.

Every bus write aimed at the slow domain goes through its own toggle handshake. The write crosses into the slow domain through a two-flop synchronizer and is applied there. An acknowledge then crosses back. A per-target busy flag stays high from the write until that acknowledge arrives. If a second write reaches a target whose first write is still pending, it is dropped and a sticky error flag is set. Any write to the status word clears that flag. Bus reads of slow-side state pass through a two-flop stage, so software reads a running counter twice.

Top module: `rtc_dual_clk`

## Requirements
- R1: After reset every readable word (offsets 0x00 to 0x14) reads 0 and `irq_o` is 0.
- R2: A write to the sub-second counter (0x00), second counter (0x04), sub-second alarm (0x08), second alarm (0x0C) or control (0x10) lands in the slow domain and reads back at the same offset once its busy flag has dropped.
- R3: While a write is pending, status bit 3 (any busy) and the target's busy bit are 1. The busy bits are 4 to 10, in the order sub-second counter, second counter, sub-second alarm, second alarm, control, sub-second clear, second clear. All of them drop to 0 once the write has landed.
- R4: A write to a target whose busy bit is 1 sets status bit 2 (error) and is dropped, and the pending value lands unchanged. A write to a different, idle target sets no error.
- R5: Any write to the status word (0x14) clears the error bit.
- R6: With control bit 0 at 0 the sub-second counter holds its value; with control bit 1 at 0 the second counter holds.
- R7: The sub-second counter counts 0 to WRAP-1 and wraps to 0. Each wrap advances the second counter only when control bit 1 is 1.
- R8: Status bit 0 becomes 1 when sub-second counting is enabled and the sub-second counter equals its alarm. Status bit 1 does the same for the second counter under control bit 1. Both flags are sticky.
- R9: `irq_o` is 1 exactly when (status bit 0 and control bit 2) or (status bit 1 and control bit 3).
- R10: Writing 1 to bit 0 or bit 1 of the clear word (0x18) clears the sub-second or the second pending flag. A 0 in either bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | Timekeeping tick clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| psel_i | input | 1 | Register port select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request, bus-clock synchronous |

## Verification
Writes are driven in three patterns. Isolated writes, each allowed to land, show that values really cross and read back. A back-to-back pair to the same target shows that the second write is dropped and the error bit is set. A back-to-back pair to different targets shows that the error check is per target and not global. Counting is run with both enables, with only the sub-second enable and with neither, so the wrap, the advance of the second counter and the hold behaviour can each be told apart. The alarm path is exercised with the interrupt enable both off and on, followed by clear writes with zero bits and with one bits. This separates the pending flag from its mask and a real clear from an ignored one.

// File: rtl/rtc_dual_clk_pkg.sv
package rtc_dual_clk_pkg;
  localparam int NUM_TGT = 7;
  // write target indices; also the status busy-bit order (bit 4 + index)
  localparam int T_SUB   = 0;
  localparam int T_SEC   = 1;
  localparam int T_ASUB  = 2;
  localparam int T_ASEC  = 3;
  localparam int T_CTRL  = 4;
  localparam int T_CLRSB = 5;
  localparam int T_CLRSC = 6;
  // word indices (address bits above the byte lane)
  localparam int W_STAT  = 5;
  localparam int W_CLR   = 6;
  // control bits
  localparam int C_EN_SUB = 0;
  localparam int C_EN_SEC = 1;
  localparam int C_IE_SUB = 2;
  localparam int C_IE_SEC = 3;
  localparam int CTRL_W   = 4;
endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/rtc_wr_chan.sv
// One tracked write path: bus-side toggle request, slow-side apply pulse, ack back.
module rtc_wr_chan #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          slow_clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          apply_o,
  output logic [DW-1:0] data_o
);
  logic          req_q;
  logic [DW-1:0] data_q;
  logic          req_s1, req_s2, req_s3;
  logic          ack_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else if (launch_i && !busy_o) begin
      req_q  <= ~req_q;
      data_q <= data_i;
    end
  end

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_s3 <= 1'b0;
    end else begin
      req_s1 <= req_q;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
    end
  end

  rtc_sync2 #(.W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_s3),
    .q_o   (ack_b)
  );

  assign apply_o = req_s2 ^ req_s3;
  assign busy_o  = req_q ^ ack_b;
  // data_q is held from launch until ack, so the slow side samples it stable
  assign data_o  = data_q;
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
  import rtc_dual_clk_pkg::*;
#(
  parameter int WRAP = 32768,
  parameter int SUBW = 15
) (
  input  logic                            slow_clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_TGT-1:0]              apply_i,
  input  logic [NUM_TGT-1:0][31:0]        wdata_i,
  output logic [SUBW-1:0]                 sub_o,
  output logic [31:0]                     sec_o,
  output logic [SUBW-1:0]                 alarm_sub_o,
  output logic [31:0]                     alarm_sec_o,
  output logic [CTRL_W-1:0]               ctrl_o,
  output logic [1:0]                      pend_o,
  output logic                            irq_o
);
  logic [SUBW-1:0]   sub_q, alarm_sub_q;
  logic [31:0]       sec_q, alarm_sec_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        pend_q;
  logic              irq_q;
  logic              sub_wrap;

  assign sub_wrap = (sub_q == SUBW'(WRAP - 1));

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q       <= '0;
      sec_q       <= '0;
      alarm_sub_q <= '0;
      alarm_sec_q <= '0;
      ctrl_q      <= '0;
      pend_q      <= '0;
      irq_q       <= 1'b0;
    end else begin
      if (apply_i[T_SUB])          sub_q <= wdata_i[T_SUB][SUBW-1:0];
      else if (ctrl_q[C_EN_SUB])   sub_q <= sub_wrap ? '0 : sub_q + 1'b1;

      if (apply_i[T_SEC])          sec_q <= wdata_i[T_SEC];
      else if (ctrl_q[C_EN_SUB] && ctrl_q[C_EN_SEC] && sub_wrap)
                                   sec_q <= sec_q + 1'b1;

      if (apply_i[T_ASUB]) alarm_sub_q <= wdata_i[T_ASUB][SUBW-1:0];
      if (apply_i[T_ASEC]) alarm_sec_q <= wdata_i[T_ASEC];
      if (apply_i[T_CTRL]) ctrl_q      <= wdata_i[T_CTRL][CTRL_W-1:0];

      // clear wins; a still-matching enabled counter re-raises next tick
      if (apply_i[T_CLRSB])                                   pend_q[0] <= 1'b0;
      else if (ctrl_q[C_EN_SUB] && sub_q == alarm_sub_q)      pend_q[0] <= 1'b1;
      if (apply_i[T_CLRSC])                                   pend_q[1] <= 1'b0;
      else if (ctrl_q[C_EN_SEC] && sec_q == alarm_sec_q)      pend_q[1] <= 1'b1;

      irq_q <= (pend_q[0] & ctrl_q[C_IE_SUB]) | (pend_q[1] & ctrl_q[C_IE_SEC]);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[T_SUB][31:SUBW], wdata_i[T_ASUB][31:SUBW],
                          wdata_i[T_CTRL][31:CTRL_W], wdata_i[T_CLRSB], wdata_i[T_CLRSC]};

  assign sub_o       = sub_q;
  assign sec_o       = sec_q;
  assign alarm_sub_o = alarm_sub_q;
  assign alarm_sec_o = alarm_sec_q;
  assign ctrl_o      = ctrl_q;
  assign pend_o      = pend_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/rtc_dual_clk.sv
module rtc_dual_clk
  import rtc_dual_clk_pkg::*;
#(
  parameter int WRAP   = 32768,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              irq_o
);
  localparam int SUBW  = $clog2(WRAP);
  localparam int WIDX  = ADDR_W - 2;
  localparam int SNAPW = 2 * SUBW + 64 + CTRL_W + 2 + 1;

  logic [WIDX-1:0]           widx;
  logic                      wr_en, st_wr, collide;
  logic [NUM_TGT-1:0]        launch, busy, apply;
  logic [NUM_TGT-1:0][31:0]  chan_in, chan_out;
  logic                      err_q;

  assign widx  = paddr_i[ADDR_W-1:2];
  assign wr_en = psel_i && penable_i && pwrite_i;
  assign st_wr = wr_en && (widx == WIDX'(W_STAT));

  always_comb begin
    for (int t = 0; t < NUM_TGT; t++) begin
      launch[t]  = 1'b0;
      chan_in[t] = pwdata_i;
    end
    for (int t = T_SUB; t <= T_CTRL; t++)
      launch[t] = wr_en && (widx == WIDX'(t));
    launch[T_CLRSB] = wr_en && (widx == WIDX'(W_CLR)) && pwdata_i[0];
    launch[T_CLRSC] = wr_en && (widx == WIDX'(W_CLR)) && pwdata_i[1];
  end

  assign collide = |(launch & busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (st_wr)   err_q <= 1'b0;
    else if (collide) err_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_chan
    rtc_wr_chan #(.DW(32)) u_chan (
      .clk_i     (clk_i),
      .slow_clk_i(slow_clk_i),
      .rst_ni    (rst_ni),
      .launch_i  (launch[g]),
      .data_i    (chan_in[g]),
      .busy_o    (busy[g]),
      .apply_o   (apply[g]),
      .data_o    (chan_out[g])
    );
  end

  logic [SUBW-1:0]   sub_s, asub_s, sub_b, asub_b;
  logic [31:0]       sec_s, asec_s, sec_b, asec_b;
  logic [CTRL_W-1:0] ctrl_s, ctrl_b;
  logic [1:0]        pend_s, pend_b;
  logic              irq_s, irq_b;

  rtc_slow_core #(.WRAP(WRAP), .SUBW(SUBW)) u_core (
    .slow_clk_i (slow_clk_i),
    .rst_ni     (rst_ni),
    .apply_i    (apply),
    .wdata_i    (chan_out),
    .sub_o      (sub_s),
    .sec_o      (sec_s),
    .alarm_sub_o(asub_s),
    .alarm_sec_o(asec_s),
    .ctrl_o     (ctrl_s),
    .pend_o     (pend_s),
    .irq_o      (irq_s)
  );

  rtc_sync2 #(.W(SNAPW)) u_rd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sub_s, sec_s, asub_s, asec_s, ctrl_s, pend_s, irq_s}),
    .q_o   ({sub_b, sec_b, asub_b, asec_b, ctrl_b, pend_b, irq_b})
  );

  always_comb begin
    prdata_o = '0;
    case (widx)
      WIDX'(T_SUB):  prdata_o = 32'(sub_b);
      WIDX'(T_SEC):  prdata_o = sec_b;
      WIDX'(T_ASUB): prdata_o = 32'(asub_b);
      WIDX'(T_ASEC): prdata_o = asec_b;
      WIDX'(T_CTRL): prdata_o = 32'(ctrl_b);
      WIDX'(W_STAT): prdata_o = 32'({busy, |busy, err_q, pend_b});
      default:       prdata_o = '0;
    endcase
  end

  logic unused_addr;
  assign unused_addr = ^paddr_i[1:0];

  assign irq_o = irq_b;
endmodule

// File: rtl/rtc_dual_clk_chk.sv
module rtc_dual_clk_chk #(
  parameter int WRAP = 32768,
  parameter int SUBW = 15,
  parameter int NT   = 7
) (
  input logic            clk_i,
  input logic            slow_clk_i,
  input logic            rst_ni,
  input logic [NT-1:0]   launch,
  input logic [NT-1:0]   busy,
  input logic [NT-1:0]   apply,
  input logic            err_q,
  input logic            st_wr,
  input logic [SUBW-1:0] sub_s,
  input logic [3:0]      ctrl_s
);
  assert_busy_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(launch & ~busy)) |=> ((busy & $past(launch & ~busy)) == $past(launch & ~busy)));

  assert_collide_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(launch & busy)) |=> err_q);

  assert_err_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(|(launch & busy)));

  assert_err_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr |=> !err_q);

  assert_sub_hold_R6: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (!ctrl_s[0] && !apply[0]) |=> $stable(sub_s));

  assert_sub_wrap_R7: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (ctrl_s[0] && !apply[0] && sub_s == SUBW'(WRAP - 1)) |=> (sub_s == '0));
endmodule

bind rtc_dual_clk rtc_dual_clk_chk #(.WRAP(WRAP), .SUBW(SUBW), .NT(NUM_TGT)) u_chk (
  .clk_i     (clk_i),
  .slow_clk_i(slow_clk_i),
  .rst_ni    (rst_ni),
  .launch    (launch),
  .busy      (busy),
  .apply     (apply),
  .err_q     (err_q),
  .st_wr     (st_wr),
  .sub_s     (sub_s),
  .ctrl_s    (ctrl_s)
);

// File: tb/rtc_dual_clk_test.sv
`timescale 1ns/1ps
module rtc_dual_clk_test;
  localparam int WRAP = 16;

  logic        clk_i = 1'b0, slow_clk_i = 1'b0, rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [4:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;       // 50 MHz bus clock
  always #50 slow_clk_i = ~slow_clk_i;

  rtc_dual_clk #(.WRAP(WRAP)) uut (
    .clk_i(clk_i), .slow_clk_i(slow_clk_i), .rst_ni(rst_ni),
    .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
    .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b1; paddr_i = a; pwdata_i = d; penable_i = 1'b0;
    @(negedge clk_i);
    penable_i = 1'b1;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = a; penable_i = 1'b0;
    @(negedge clk_i);
    penable_i = 1'b1;
    #2 d = prdata_o;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] st;
    bit idle = 0;
    for (int i = 0; i < 100 && !idle; i++) begin
      bus_rd(5'h14, st);
      idle = (st[3] == 1'b0);
    end
    chk({req, " idle"}, 32'(idle), 32'd1);
    repeat (20) @(posedge clk_i);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      bus_rd(5'(a * 4), d);
      chk("R1 reset word", d, 32'd0);
    end
    @(negedge clk_i);
    chk("R1 irq reset", 32'(irq_o), 32'd0);
  endtask

  task automatic t_write_back;
    logic [31:0] d;
    bus_wr(5'h10, 32'd0);
    bus_wr(5'h08, 32'd5);
    wait_idle("R2");
    bus_wr(5'h0C, 32'd3);
    wait_idle("R2");
    bus_wr(5'h00, 32'd7);
    wait_idle("R2");
    bus_wr(5'h04, 32'h1234);
    wait_idle("R2");
    bus_rd(5'h08, d); chk("R2 sub alarm", d, 32'd5);
    bus_rd(5'h0C, d); chk("R2 sec alarm", d, 32'd3);
    bus_rd(5'h00, d); chk("R2 sub counter", d, 32'd7);
    bus_rd(5'h04, d); chk("R2 sec counter", d, 32'h1234);
    bus_rd(5'h10, d); chk("R2 control", d, 32'd0);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    bus_wr(5'h04, 32'd0);
    bus_rd(5'h14, d);
    chk("R3 busy sec counter", d & 32'h7F8, 32'h028);
    wait_idle("R3");
    bus_rd(5'h14, d);
    chk("R3 busy cleared", d & 32'h7F8, 32'h000);
    bus_wr(5'h18, 32'd3);
    bus_rd(5'h14, d);
    chk("R3 busy both clears", d & 32'h7F8, 32'h608);
    wait_idle("R3");
  endtask

  task automatic t_collision;
    logic [31:0] d;
    bus_wr(5'h00, 32'd3);
    bus_wr(5'h00, 32'd9);
    bus_rd(5'h14, d);
    chk("R4 error set", 32'(d[2]), 32'd1);
    wait_idle("R4");
    bus_rd(5'h00, d);
    chk("R4 pending value kept", d, 32'd3);
    bus_wr(5'h14, 32'd0);
    bus_rd(5'h14, d);
    chk("R5 error cleared", 32'(d[2]), 32'd0);
    bus_wr(5'h08, 32'd5);
    bus_wr(5'h0C, 32'd3);
    bus_rd(5'h14, d);
    chk("R4 no error other target", 32'(d[2]), 32'd0);
    wait_idle("R4");
  endtask

  task automatic t_count;
    logic [31:0] s1, s2, c1;
    bus_wr(5'h00, 32'd0); wait_idle("R6");
    bus_wr(5'h04, 32'd0); wait_idle("R6");
    repeat (100) @(posedge clk_i);
    bus_rd(5'h00, s1);
    chk("R6 sub held", s1, 32'd0);
    bus_wr(5'h10, 32'd3); wait_idle("R7");
    repeat (200) @(posedge clk_i);
    bus_wr(5'h10, 32'd0); wait_idle("R7");
    bus_rd(5'h04, c1);
    bus_rd(5'h00, s1);
    chk("R7 sec advanced", 32'(c1 >= 2 && c1 <= 5), 32'd1);
    chk("R7 sub in range", 32'(s1 < WRAP), 32'd1);
    repeat (100) @(posedge clk_i);
    bus_rd(5'h00, s2);
    chk("R6 sub holds when off", s2, s1);
    bus_rd(5'h04, s2);
    chk("R6 sec holds when off", s2, c1);
    bus_wr(5'h10, 32'd1); wait_idle("R7");
    repeat (200) @(posedge clk_i);
    bus_wr(5'h10, 32'd0); wait_idle("R7");
    bus_rd(5'h04, s2);
    chk("R7 no sec advance without bit1", s2, c1);
    bus_rd(5'h00, s2);
    chk("R7 sub wrapped in range", 32'(s2 < WRAP), 32'd1);
  endtask

  task automatic t_alarm;
    logic [31:0] d;
    bus_wr(5'h08, 32'd5); wait_idle("R8");
    bus_wr(5'h00, 32'd0); wait_idle("R8");
    bus_wr(5'h18, 32'd3); wait_idle("R10");
    bus_rd(5'h14, d);
    chk("R10 both cleared", d & 32'h3, 32'd0);
    bus_wr(5'h10, 32'd1); wait_idle("R8");
    repeat (200) @(posedge clk_i);
    bus_rd(5'h14, d);
    chk("R8 sub pending", 32'(d[0]), 32'd1);
    chk("R9 masked irq", 32'(irq_o), 32'd0);
    bus_wr(5'h10, 32'd5); wait_idle("R9");
    chk("R9 irq sub", 32'(irq_o), 32'd1);
    bus_wr(5'h10, 32'd4); wait_idle("R9");
    bus_wr(5'h18, 32'd0); wait_idle("R10");
    bus_rd(5'h14, d);
    chk("R10 zero ignored", 32'(d[0]), 32'd1);
    chk("R10 irq kept", 32'(irq_o), 32'd1);
    bus_wr(5'h18, 32'd1); wait_idle("R10");
    bus_rd(5'h14, d);
    chk("R10 sub cleared", 32'(d[0]), 32'd0);
    chk("R9 irq dropped", 32'(irq_o), 32'd0);
    bus_wr(5'h0C, 32'd1); wait_idle("R8");
    bus_wr(5'h04, 32'd0); wait_idle("R8");
    bus_wr(5'h00, 32'd0); wait_idle("R8");
    bus_wr(5'h10, 32'hB); wait_idle("R8");
    repeat (200) @(posedge clk_i);
    bus_rd(5'h14, d);
    chk("R8 sec pending", 32'(d[1]), 32'd1);
    chk("R9 irq sec", 32'(irq_o), 32'd1);
    bus_wr(5'h10, 32'h8); wait_idle("R10");
    bus_wr(5'h18, 32'd2); wait_idle("R10");
    bus_rd(5'h14, d);
    chk("R10 sec cleared", 32'(d[1]), 32'd0);
    chk("R10 sub untouched", 32'(d[0]), 32'd1);
    chk("R9 irq off with ie0 low", 32'(irq_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1'b1;
    repeat (3) @(posedge slow_clk_i);
    t_reset;
    t_write_back;
    t_busy;
    t_collision;
    t_count;
    t_alarm;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule